// File: doc/BRIEF.md
# SPI Slave Pause and Sleep Controller

This block sits beside the command engine of an SPI slave memory. It governs two ways in which the engine must stop working. The first is a pause requested by the host through the hold pin. The second is a low-power sleep state that the host requests with an opcode. All pins are sampled by the system clock through a synchronizer. From those samples the block drives a freeze level, which stalls the engine's shifters and counters. It also drives an enable for the serial output driver.

A pause begins only while chip select is low. The SCK level seen at the moment the pause begins is stored. The pause ends only when the hold pin is released while SCK is at that same level. If chip select rises during a pause, the command is cut off with a one-cycle abort pulse. A second flag on that pulse tells the engine whether its opcode had been recognised yet. If it had not, the write-enable latch must be left as it was.

The engine pulses `sleep_cmd` when it decodes the sleep opcode. The next chip-select rise then puts the block to sleep, unless an SCK rising edge comes first. A chip-select fall wakes the block. The `ready` flag then stays low for a fixed recovery count of system clocks. A second chip-select fall inside that recovery window sets a sticky protocol-error flag.

Top module: `spi_pause_sleep_ctrl`

## Requirements
- R1: After reset, `freeze`, `abort`, `abort_pre_op` and `proto_err` are 0 and `ready` is 1.
- R2: While `cs_n` is high, `hold_n` low never starts a pause: `freeze` stays 0.
- R3: While a pause or sleep is in effect, `freeze` is 1 and `so_en` is 0 even when `out_req` is 1. Outside them, `so_en` equals `out_req`. A pause that ends with the hold pin released produces no abort.
- R4: A pause entered while `sck` is 0 stays in effect when `hold_n` rises with `sck` at 1. It ends once `hold_n` is 1 and `sck` is 0.
- R5: A pause entered while `sck` is 1 stays in effect when `hold_n` rises with `sck` at 0. It ends once `hold_n` is 1 and `sck` is 1.
- R6: A `cs_n` rise during a pause ends the pause. It produces exactly one single-cycle `abort` pulse. `abort_pre_op` is 1 in that same cycle if and only if `op_known` was 0.
- R7: A `cs_n` rise after a `sleep_cmd` pulse enters sleep: `freeze` is 1 and `ready` is 0. An SCK falling edge in between does not prevent this, and neither does an SCK that stays high.
- R8: An `sck` rising edge between the `sleep_cmd` pulse and the `cs_n` rise cancels the sleep entry: `ready` stays 1 and `freeze` stays 0.
- R9: While asleep, activity on `sck`, `hold_n` and `sleep_cmd` has no effect. The block stays frozen and not ready, with no abort.
- R10: A `cs_n` fall while asleep starts recovery. `ready` returns to 1, and `freeze` to 0, exactly SYNC_STAGES + 1 + REC_CYCLES clock cycles after `cs_n` falls. Pins reach the logic after SYNC_STAGES flops.
- R11: A `cs_n` fall during recovery sets `proto_err` to 1. The flag stays 1 until reset. It does not change the moment `ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin level |
| hold_n | input | 1 | Hold pin, active low |
| sleep_cmd | input | 1 | One-cycle pulse: sleep opcode decoded |
| op_known | input | 1 | Engine has recognised the current opcode |
| out_req | input | 1 | Engine wants to drive serial output |
| freeze | output | 1 | Stall command progress |
| so_en | output | 1 | Serial output driver enable |
| abort | output | 1 | One-cycle pulse: command cut off during pause |
| abort_pre_op | output | 1 | With abort: opcode was not yet recognised |
| ready | output | 1 | Commands may be accepted |
| proto_err | output | 1 | Sticky: chip select fell again during recovery |

## Verification
Pause exit depends on two pins and on a stored SCK phase. The stimulus that is hardest to produce is a release of the hold pin at the wrong SCK level followed by a correction of the level, since that is the case where the exit must wait. Random vectors of chip select, hold and SCK, each held longer than the synchronizer latency, are compared against a bench model of the pause rules. Directed sequences produce the mismatched-level release, and also the sleep cancel and the chip-select bounce during recovery. For recovery, the bench counts cycles from the chip-select fall and compares the count with the exact latency.

// File: rtl/spi_pause_sleep_pkg.sv
package spi_pause_sleep_pkg;

    typedef enum logic {
        PS_RUN,
        PS_PAUSED
    } pause_st_e;

    typedef enum logic [1:0] {
        SL_AWAKE,
        SL_ARMED,
        SL_DORMANT,
        SL_WAKING
    } sleep_st_e;

    typedef struct packed {
        pause_st_e st;
        logic      phase;
        logic      abort;
        logic      pre_op;
    } pause_regs_t;

    typedef struct packed {
        logic cs_prev;
        logic sck_prev;
    } edge_regs_t;

endpackage

// File: rtl/spi_ps_sync.sv
module spi_ps_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_o
);

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb chain_d[s] = pin_i;
            end else begin : g_next
                always_comb chain_d[s] = chain_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= chain_d[s];
            end
        end
    endgenerate

    assign pin_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_ps_pause.sv
module spi_ps_pause
    import spi_pause_sleep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cs_lo,
    input  logic hold_lo,
    input  logic sck_hi,
    input  logic op_known,
    output logic paused,
    output logic abort,
    output logic abort_pre_op
);

    pause_regs_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        r_d.abort  = 1'b0;
        r_d.pre_op = 1'b0;
        unique case (r_q.st)
            PS_RUN: begin
                if (enable && cs_lo && hold_lo) begin
                    r_d.st    = PS_PAUSED;
                    r_d.phase = sck_hi;
                end
            end
            PS_PAUSED: begin
                if (!cs_lo) begin
                    r_d.st     = PS_RUN;
                    r_d.abort  = 1'b1;
                    r_d.pre_op = !op_known;
                end else if (!hold_lo && (sck_hi == r_q.phase)) begin
                    r_d.st = PS_RUN;
                end
            end
            default: r_d.st = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PS_RUN, phase: 1'b0, abort: 1'b0, pre_op: 1'b0};
        else        r_q <= r_d;
    end

    assign paused       = (r_q.st == PS_PAUSED);
    assign abort        = r_q.abort;
    assign abort_pre_op = r_q.pre_op;

endmodule

// File: rtl/spi_ps_sleep.sv
module spi_ps_sleep
    import spi_pause_sleep_pkg::*;
#(
    parameter int REC_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_cmd,
    input  logic cs_rise,
    input  logic cs_fall,
    input  logic sck_rise,
    output logic dormant,
    output logic ready,
    output logic proto_err
);

    localparam int CW = $clog2(REC_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(REC_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    typedef struct packed {
        sleep_st_e     st;
        logic [CW-1:0] cnt;
        logic          err;
    } sleep_regs_t;

    sleep_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SL_AWAKE: begin
                if (sleep_cmd) r_d.st = SL_ARMED;
            end
            SL_ARMED: begin
                if (sck_rise)     r_d.st = SL_AWAKE;
                else if (cs_rise) r_d.st = SL_DORMANT;
            end
            SL_DORMANT: begin
                if (cs_fall) begin
                    r_d.st  = SL_WAKING;
                    r_d.cnt = CNT_LOAD;
                end
            end
            SL_WAKING: begin
                if (cs_fall) r_d.err = 1'b1;
                if (r_q.cnt <= CNT_LAST) begin
                    r_d.st  = SL_AWAKE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_LAST;
                end
            end
            default: r_d.st = SL_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: SL_AWAKE, cnt: '0, err: 1'b0};
        else        r_q <= r_d;
    end

    assign dormant   = (r_q.st == SL_DORMANT) || (r_q.st == SL_WAKING);
    assign ready     = (r_q.st == SL_AWAKE) || (r_q.st == SL_ARMED);
    assign proto_err = r_q.err;

endmodule

// File: rtl/spi_pause_sleep_ctrl.sv
module spi_pause_sleep_ctrl
    import spi_pause_sleep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REC_CYCLES  = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    input  logic sleep_cmd,
    input  logic op_known,
    input  logic out_req,
    output logic freeze,
    output logic so_en,
    output logic abort,
    output logic abort_pre_op,
    output logic ready,
    output logic proto_err
);

    localparam int PINS = 3;
    localparam logic [PINS-1:0] PIN_IDLE = 3'b101; // {cs_n, sck, hold_n}

    logic [PINS-1:0] pins_s;
    logic cs_s, sck_s, hold_s;

    spi_ps_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_i({cs_n, sck, hold_n}),
        .pin_o(pins_s)
    );

    assign {cs_s, sck_s, hold_s} = pins_s;

    edge_regs_t e_q, e_d;

    always_comb begin
        e_d          = e_q;
        e_d.cs_prev  = cs_s;
        e_d.sck_prev = sck_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{cs_prev: 1'b1, sck_prev: 1'b0};
        else        e_q <= e_d;
    end

    logic cs_rise, cs_fall, sck_rise;
    assign cs_rise  = cs_s && !e_q.cs_prev;
    assign cs_fall  = !cs_s && e_q.cs_prev;
    assign sck_rise = sck_s && !e_q.sck_prev;

    logic paused, dormant, ready_w;

    spi_ps_sleep #(
        .REC_CYCLES(REC_CYCLES)
    ) i_sleep (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_cmd(sleep_cmd),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall),
        .sck_rise (sck_rise),
        .dormant  (dormant),
        .ready    (ready_w),
        .proto_err(proto_err)
    );

    spi_ps_pause i_pause (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (ready_w),
        .cs_lo       (!cs_s),
        .hold_lo     (!hold_s),
        .sck_hi      (sck_s),
        .op_known    (op_known),
        .paused      (paused),
        .abort       (abort),
        .abort_pre_op(abort_pre_op)
    );

    assign freeze = paused || dormant;
    assign so_en  = out_req && !freeze;
    assign ready  = ready_w;

endmodule

// File: rtl/spi_pause_sleep_ctrl_chk.sv
module spi_pause_sleep_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic hold_n,
    input logic sleep_cmd,
    input logic op_known,
    input logic out_req,
    input logic freeze,
    input logic so_en,
    input logic abort,
    input logic abort_pre_op,
    input logic ready,
    input logic proto_err
);

    p_so_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> !so_en);

    p_so_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        so_en |-> out_req);

    p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);

    p_preop_with_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pre_op |-> abort);

    p_abort_after_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort) |-> $past(freeze));

    p_notready_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> freeze);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

endmodule

bind spi_pause_sleep_ctrl spi_pause_sleep_ctrl_chk u_chk (.*);

// File: tb/test_spi_pause_sleep_ctrl.sv
module test_spi_pause_sleep_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int REC        = 40;
    localparam int SETTLE     = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1;
    logic sleep_cmd = 1'b0, op_known = 1'b0, out_req = 1'b0;
    logic freeze, so_en, abort, abort_pre_op, ready, proto_err;

    int n_tests = 0;
    int n_fail  = 0;
    int abort_cnt = 0;
    int preop_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (abort) abort_cnt++;
        if (abort_pre_op) preop_cnt++;
    end

    spi_pause_sleep_ctrl #(
        .SYNC_STAGES(SYNC),
        .REC_CYCLES (REC)
    ) i_spi_pause_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .sleep_cmd(sleep_cmd), .op_known(op_known), .out_req(out_req),
        .freeze(freeze), .so_en(so_en), .abort(abort),
        .abort_pre_op(abort_pre_op), .ready(ready), .proto_err(proto_err)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // Bench model of pause rules (R2, R4, R5, R6)
    bit m_held = 1'b0;
    bit m_phase = 1'b0;
    int m_aborts = 0;

    function automatic bit exp_so(input bit req, input bit frz);
        return req && !frz;
    endfunction

    task automatic model_step(input bit c, input bit h, input bit s);
        if (!m_held) begin
            if (!c && !h) begin
                m_held = 1'b1;
                m_phase = s;
            end
        end else begin
            if (c) begin
                m_held = 1'b0;
                m_aborts++;
            end else if (h && (s == m_phase)) begin
                m_held = 1'b0;
            end
        end
    endtask

    task automatic pulse_sleep();
        sleep_cmd = 1'b1;
        tick(1);
        sleep_cmd = 1'b0;
        tick(1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int a0, p0, lat;
        void'($urandom(32'h5A17));
        tick(3);
        rst_n = 1'b1;
        tick(SETTLE);

        // R1 reset state
        check_eq("R1 freeze", freeze, 0);
        check_eq("R1 ready", ready, 1);
        check_eq("R1 abort", abort_cnt, 0);
        check_eq("R1 proto_err", proto_err, 0);

        // R2 hold ignored with CS high
        out_req = 1'b1;
        hold_n = 1'b0;
        tick(SETTLE);
        check_eq("R2 freeze", freeze, 0);
        check_eq("R3 so_en follows", so_en, 1);
        hold_n = 1'b1;
        tick(SETTLE);

        // R4 pause begun with SCK low
        a0 = abort_cnt;
        cs_n = 1'b0; sck = 1'b0; tick(SETTLE);
        hold_n = 1'b0; tick(SETTLE);
        check_eq("R3 freeze in pause", freeze, 1);
        check_eq("R3 so_en in pause", so_en, 0);
        sck = 1'b1; tick(SETTLE);
        hold_n = 1'b1; tick(SETTLE);
        check_eq("R4 wrong phase release", freeze, 1);
        sck = 1'b0; tick(SETTLE);
        check_eq("R4 release", freeze, 0);
        check_eq("R3 no abort on release", abort_cnt, a0);

        // R5 pause begun with SCK high
        sck = 1'b1; tick(SETTLE);
        hold_n = 1'b0; tick(SETTLE);
        check_eq("R5 enter", freeze, 1);
        sck = 1'b0; tick(SETTLE);
        hold_n = 1'b1; tick(SETTLE);
        check_eq("R5 wrong phase release", freeze, 1);
        sck = 1'b1; tick(SETTLE);
        check_eq("R5 release", freeze, 0);

        // R6 abort before opcode known
        a0 = abort_cnt; p0 = preop_cnt;
        op_known = 1'b0;
        hold_n = 1'b0; tick(SETTLE);
        cs_n = 1'b1; tick(SETTLE);
        check_eq("R6 abort count", abort_cnt, a0 + 1);
        check_eq("R6 pre_op set", preop_cnt, p0 + 1);
        check_eq("R6 freeze cleared", freeze, 0);
        // R6 abort after opcode known
        op_known = 1'b1;
        cs_n = 1'b0; tick(SETTLE);
        check_eq("R6 re-enter", freeze, 1);
        cs_n = 1'b1; tick(SETTLE);
        check_eq("R6 abort count 2", abort_cnt, a0 + 2);
        check_eq("R6 pre_op clear", preop_cnt, p0 + 1);
        hold_n = 1'b1; sck = 1'b0; tick(SETTLE);

        // Random pause traffic against model (R2 R4 R5 R6 R3)
        m_held = 1'b0;
        m_aborts = abort_cnt;
        for (int i = 0; i < 400; i++) begin
            bit c, h, s;
            c = ($urandom % 4) == 0;
            h = ($urandom % 2) == 0;
            s = $urandom % 2;
            out_req = $urandom % 2;
            op_known = $urandom % 2;
            cs_n = c; hold_n = h; sck = s;
            model_step(c, h, s);
            tick(SETTLE);
            check_eq("R4 R5 random freeze", freeze, m_held);
            check_eq("R3 random so_en", so_en, exp_so(out_req, m_held));
        end
        check_eq("R6 random aborts", abort_cnt, m_aborts);
        cs_n = 1'b1; hold_n = 1'b1; sck = 1'b0; out_req = 1'b1;
        tick(SETTLE);

        // R8 sleep cancelled by SCK rising edge
        cs_n = 1'b0; tick(SETTLE);
        pulse_sleep();
        sck = 1'b1; tick(SETTLE);
        cs_n = 1'b1; tick(SETTLE);
        check_eq("R8 ready", ready, 1);
        check_eq("R8 freeze", freeze, 0);

        // R7 sleep entry with only a falling SCK edge
        cs_n = 1'b0; tick(SETTLE);
        pulse_sleep();
        sck = 1'b0; tick(SETTLE);
        cs_n = 1'b1; tick(SETTLE);
        check_eq("R7 freeze", freeze, 1);
        check_eq("R7 ready", ready, 0);
        check_eq("R7 so_en", so_en, 0);

        // R9 activity ignored while asleep
        a0 = abort_cnt;
        for (int i = 0; i < 6; i++) begin
            sck = ~sck; hold_n = ~hold_n; tick(SETTLE);
        end
        pulse_sleep();
        hold_n = 1'b1; sck = 1'b0; tick(SETTLE);
        check_eq("R9 freeze", freeze, 1);
        check_eq("R9 ready", ready, 0);
        check_eq("R9 no abort", abort_cnt, a0);

        // R10 wake latency
        cs_n = 1'b0;
        lat = 0;
        while (ready !== 1'b1 && lat < 10 * REC) begin
            tick(1);
            lat++;
        end
        check_eq("R10 wake latency", lat, SYNC + 1 + REC);
        check_eq("R10 freeze after wake", freeze, 0);
        check_eq("R11 no error on clean wake", proto_err, 0);
        cs_n = 1'b1; tick(SETTLE);

        // R7 sleep with SCK staying high (mode 3 style)
        sck = 1'b1; cs_n = 1'b0; tick(SETTLE);
        pulse_sleep();
        cs_n = 1'b1; tick(SETTLE);
        check_eq("R7 sck high sleep", ready, 0);

        // R11 CS bounce during recovery
        cs_n = 1'b0;
        lat = 0;
        while (ready !== 1'b1 && lat < 10 * REC) begin
            tick(1);
            lat++;
            if (lat == 10) cs_n = 1'b1;
            if (lat == 20) cs_n = 1'b0;
        end
        check_eq("R11 latency unchanged", lat, SYNC + 1 + REC);
        check_eq("R11 proto_err set", proto_err, 1);
        cs_n = 1'b1; tick(SETTLE);
        cs_n = 1'b0; hold_n = 1'b0; tick(SETTLE);
        hold_n = 1'b1; cs_n = 1'b1; tick(SETTLE);
        check_eq("R11 proto_err sticky", proto_err, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule